// File: doc/BRIEF.md
# Strobed Read Front End for a 256K x 16 Read-Only Memory

This block sits between a shared 16-bit pin bus and a 262,144-word by 16-bit read-only store. Row and column strobes that work as on a dynamic RAM control it. Both strobes are active low and are sampled on the system clock. The same pins carry three things in turn: the row address while the row strobe falls, the column address while the column strobe falls, and the read word once the access latency has passed. The pad's tri-state cell is split into an input, an output and an output enable. When the enable is low, the external system may drive addresses onto the pins.

There are two read modes. In random mode, every column strobe takes a fresh column from the pins and returns one word from the open row. In consecutive mode, only the first column strobe of an access takes a column from the pins. Each later column strobe advances an internal 18-bit word counter by one, so a burst returns one word per column cycle without any further address traffic. The mode is fixed when the row strobe falls. The store is a combinational function of the address, so it needs no memory array.

Top module: `rcrom_front`

## Requirements
- R1: While reset is asserted and after it is released with no strobe activity, `bus_oe` is 0.
- R2: On the clock edge that first samples `row_stb_n` low after a high sample, the row is taken from `bus_in[8:0]` and the mode from `burst_sel` (1 = consecutive, 0 = random). Changes of `burst_sel` later in the access have no effect.
- R3: In random mode, each column strobe fall (a low sample after a high sample, while an access is open) forms the word address row*512 + `bus_in[8:0]`. While `bus_oe` stays high, `bus_out` does not change.
- R4: In consecutive mode, the first column strobe fall of an access takes its column from the pins, as in R3. Each later fall ignores the pins and adds 1 to the 18-bit word address. Column 511 carries into the next row, and address 0x3FFFF wraps to 0.
- R5: `bus_oe` is high only while an access is open, the column strobe was sampled low, and the latency has elapsed. A high sample of `row_stb_n` closes the access and clears `bus_oe` after that edge, even while the column strobe is still low.
- R6: With a latency of LAT = 2, `bus_oe` rises and `bus_out` carries the word right after the second clock edge that samples the column strobe low. After the first such edge, `bus_oe` is still 0.
- R7: The word stored at address a is ((a * 40503) mod 65536) XOR ((a >> 16) << 14).
- R8: Column strobe pulses while the row strobe is high do not enable the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_stb_n | input | 1 | Active-low row strobe; its fall opens an access |
| col_stb_n | input | 1 | Active-low column strobe; each fall requests one word |
| burst_sel | input | 1 | Mode select sampled at the row strobe fall; 1 = consecutive |
| bus_in | input | 16 | Value seen on the shared pins (row or column address in bits 8:0) |
| bus_out | output | 16 | Read word to be driven onto the shared pins |
| bus_oe | output | 1 | Pin driver enable; 0 releases the pins to high impedance |

## Verification
Random reads are applied in one row with scattered columns, including column 0 and the corner word at row 511, column 511. These catch a swapped or truncated row/column split. Consecutive bursts start at column 510 so that the counter must carry into the next row, and start at 0x3FFFE so that it must wrap to 0; in both, deliberately wrong columns are left on the pins to show that later strobes ignore them. Further patterns toggle the mode input mid-access, pulse the column strobe with no row open, and raise the row strobe while data is driven. These separate a mode that is sampled once from one that is followed live, and separate a driver gated by the open access from one gated only by the column strobe.

// File: rtl/rcrom_front.sv
module rcrom_front #(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_stb_n,
  input  logic              col_stb_n,
  input  logic              burst_sel,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int CNT_W  = $clog2(LAT + 1);
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);

  function automatic logic [DATA_W-1:0] rom_word(input logic [ADDR_W-1:0] a);
    logic [ADDR_W+15:0] p;
    logic [ADDR_W-1:0]  hi;
    p  = {16'd0, a} * (ADDR_W+16)'(40503);
    hi = (a >> 16) << 14;
    return p[DATA_W-1:0] ^ DATA_W'(hi);
  endfunction

  logic              ras_q, cas_q, act_q, burst_q, first_q;
  logic [ROW_W-1:0]  row_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  lat_q;
  logic [DATA_W-1:0] dout_q;

  wire ras_fall = ras_q & ~row_stb_n;
  wire cas_fall = act_q & cas_q & ~col_stb_n;
  wire [ADDR_W-1:0] pin_addr  = {row_q, bus_in[COL_W-1:0]};
  wire [ADDR_W-1:0] next_addr = (burst_q & ~first_q) ? addr_q + ADDR_W'(1) : pin_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      act_q   <= 1'b0;
      burst_q <= 1'b0;
      first_q <= 1'b0;
      row_q   <= '0;
      addr_q  <= '0;
      lat_q   <= '0;
      dout_q  <= '0;
    end else begin
      ras_q  <= row_stb_n;
      cas_q  <= col_stb_n;
      dout_q <= rom_word(addr_q);
      if (row_stb_n) begin
        act_q <= 1'b0;
        lat_q <= '0;
      end else if (ras_fall) begin
        act_q   <= 1'b1;
        row_q   <= bus_in[ROW_W-1:0];
        burst_q <= burst_sel;
        first_q <= 1'b1;
        lat_q   <= '0;
      end else if (cas_fall) begin
        addr_q  <= next_addr;
        first_q <= 1'b0;
        lat_q   <= CNT_W'(1);
      end else if (col_stb_n) begin
        lat_q <= '0;
      end else if (act_q && lat_q != '0 && lat_q != LAT_C) begin
        lat_q <= lat_q + CNT_W'(1);
      end
    end
  end

  assign bus_oe  = act_q & ~cas_q & (lat_q == LAT_C);
  assign bus_out = dout_q;
endmodule

// File: rtl/rcrom_front_chk.sv
module rcrom_front_chk #(
  parameter int DATA_W = 16,
  parameter int LAT    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              row_stb_n,
  input logic              col_stb_n,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_out,
  input logic              mode_q
);
  localparam int RW = $clog2(LAT + 2);
  logic [RW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (col_stb_n) low_run <= '0;
    else if (low_run != RW'(LAT + 1)) low_run <= low_run + RW'(1);
  end

  // R5
  oe_needs_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(row_stb_n) |-> !bus_oe);
  // R5
  oe_needs_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(col_stb_n) |-> !bus_oe);
  // R6
  oe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> low_run == RW'(LAT));
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_out));
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(row_stb_n) && !$past(row_stb_n, 2)) |-> $stable(mode_q));
endmodule

bind rcrom_front rcrom_front_chk #(.DATA_W(DATA_W), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
  .bus_oe(bus_oe), .bus_out(bus_out), .mode_q(burst_q)
);

// File: tb/rcrom_front_tb.sv
module rcrom_front_tb;
  localparam int LAT = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, burst = 1'b0;
  logic [15:0] bin = '0;
  logic [15:0] bout;
  logic oe;
  int n_chk = 0, n_fail = 0;
  bit started = 0, done = 0;

  always #2.5 clk = ~clk;

  rcrom_front u_dut (.clk(clk), .rst_n(rst_n), .row_stb_n(ras_n), .col_stb_n(cas_n),
                     .burst_sel(burst), .bus_in(bin), .bus_out(bout), .bus_oe(oe));

  function automatic int ref_word(int a);
    return ((a * 40503) & 'hFFFF) ^ ((a >>> 16) << 14);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, updated on each rising edge
  int m_act = 0, m_row = 0, m_addr = 0, m_cnt = 0, m_first = 0, m_burst = 0;
  int m_pras = 1, m_pcas = 1;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_cnt = 0; m_addr = 0; m_pras = 1; m_pcas = 1;
    end else begin
      if (ras_n) begin
        m_act = 0; m_cnt = 0;
      end else if (m_pras == 1) begin
        m_act = 1; m_row = bin & 511; m_burst = burst; m_first = 1; m_cnt = 0;
      end else if (m_act == 1 && !cas_n && m_pcas == 1) begin
        if (m_burst == 1 && m_first == 0) m_addr = (m_addr + 1) % 262144;
        else m_addr = m_row * 512 + (bin & 511);
        m_first = 0; m_cnt = 1;
      end else if (cas_n) begin
        m_cnt = 0;
      end else if (m_act == 1 && m_cnt > 0 && m_cnt < LAT) begin
        m_cnt++;
      end
      m_pras = ras_n; m_pcas = cas_n;
    end
  end

  always @(negedge clk) if (rst_n && started) begin
    int e_oe;
    e_oe = (m_act == 1 && m_cnt == LAT) ? 1 : 0;
    chk("R5 per-cycle bus_oe", oe, e_oe);
    if (e_oe == 1) chk("R7 per-cycle bus_out", bout, ref_word(m_addr));
  end

  task automatic open_row(int row, bit b);
    @(negedge clk); ras_n = 1'b0; burst = b; bin = 16'(row);
  endtask

  task automatic close_row();
    @(negedge clk); ras_n = 1'b1;
    @(negedge clk); chk("R5 released after row strobe high", oe, 0);
  endtask

  task automatic cas_word(int col, int exp_addr, string tag);
    @(negedge clk); bin = 16'(col); cas_n = 1'b0;
    @(negedge clk); chk({tag, " R6 oe low after first edge"}, oe, 0);
    @(negedge clk);
    chk({tag, " R6 oe high after second edge"}, oe, 1);
    chk({tag, " R7 word"}, bout, ref_word(exp_addr));
    cas_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R1 reset bus_oe", oe, 0);
    rst_n = 1'b1; started = 1;
    @(negedge clk); chk("R1 idle bus_oe", oe, 0);

    open_row(5, 0);
    cas_word(17, 5*512+17, "R3 random");
    cas_word(300, 5*512+300, "R3 random");
    cas_word(0, 5*512, "R3 random col0");
    close_row();

    open_row(511, 0);
    cas_word(511, 262143, "R3 top corner");
    close_row();

    open_row(3, 1);
    cas_word(510, 3*512+510, "R4 first from pins");
    cas_word(7, 3*512+511, "R4 pins ignored");
    cas_word(99, 4*512, "R4 carry into row");
    cas_word(0, 4*512+1, "R4 increment");
    close_row();

    open_row(511, 1);
    cas_word(510, 262142, "R4 near top");
    cas_word(3, 262143, "R4 top");
    cas_word(3, 0, "R4 wrap");
    cas_word(3, 1, "R4 after wrap");
    close_row();

    open_row(8, 0);
    @(negedge clk); burst = 1'b1;
    cas_word(10, 8*512+10, "R2 mode held random");
    cas_word(20, 8*512+20, "R2 mode held random");
    close_row();

    @(negedge clk); cas_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R8 column strobe without row", oe, 0);
    end
    cas_n = 1'b1;

    open_row(2, 0);
    @(negedge clk); bin = 16'd40; cas_n = 1'b0;
    @(negedge clk);
    @(negedge clk); chk("R5 driving before close", oe, 1);
    ras_n = 1'b1;
    @(negedge clk); chk("R5 row high with column low", oe, 0);
    cas_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule